// File: doc/BRIEF.md
# Counterflow Systolic FIR Filter with Stationary Accumulators

This block is a finite impulse response filter built as a linear chain of processing elements. Every element keeps one output sample in its own accumulator until that sample is complete. Input samples move through the chain from the first element towards the last, one element per cycle. Coefficients move the opposite way, also one element per cycle. A sample and a coefficient therefore meet in an element only on alternate cycles. For this reason the block accepts a sample only in every second cycle, and it marks that cycle on an output so the user knows when to present data.

The coefficients arrive as a short stream, one value per write strobe. The block keeps them in a small shift store and feeds them into the far end of the chain in a repeating order. When an element has made its last product for an output, it passes the finished sum to an unload chain and clears its accumulator. The unload chain carries results towards the last element. Results leave the block in sample order, one per accepted slot, each marked by a valid flag.

Top module: `fir_cf_top`

## Requirements
- R1: `samp_slot` is high in the first cycle after reset is released. After that it toggles every cycle, so a sample slot is open on alternate cycles only.
- R2: On a slot cycle, `samp_data` enters the filter if `samp_valid` is high. If `samp_valid` is low, a zero sample enters. Sample inputs on cycles with `samp_slot` low have no effect on any result.
- R3: Each cycle with `coef_valid` high shifts `coef_data` into the coefficient store. After TAPS writes, the first value written is tap 0 and multiplies the newest sample. The last value written is tap TAPS-1 and multiplies the oldest sample in the window.
- R4: The result for slot n is the sum over k = 0..TAPS-1 of tap(k) times x(n-k). Samples and coefficients are two's complement. The result is exact in two's complement at ACC_W = DATA_W + COEF_W + 4 bits, including the case where every product has its largest magnitude.
- R5: The sample accepted at clock edge E has its result on `res_data` with `res_valid` high in the cycle after edge E + TAPS.
- R6: `res_valid` is high only in result cycles and is never high in two cycles in a row. Each element does one multiply-accumulate every second cycle.
- R7: While reset is asserted, `res_valid` is 0, `res_data` is 0 and `samp_slot` is 1.
- R8: A new coefficient set applies to every product with a sample accepted at least TAPS cycles after the last coefficient write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_valid | input | 1 | Sample present for the current slot |
| samp_data | input | DATA_W | Two's complement input sample |
| samp_slot | output | 1 | High in cycles where a sample is taken |
| coef_valid | input | 1 | Coefficient write strobe |
| coef_data | input | COEF_W | Two's complement coefficient, tap 0 first |
| res_valid | output | 1 | Completed result on `res_data` |
| res_data | output | ACC_W | Filter output sample |

## Verification
The bench feeds an impulse to show tap order; a store that shifted the wrong way would produce the response reversed in time. It drives random data with `samp_valid` set on off-slot cycles. A filter that sampled on the wrong phase, or that failed to zero empty slots, would then produce sums that do not match the model. It runs every product at full negative magnitude, where a narrow or unsigned accumulator would wrap. It also reloads the taps between bursts, so that a store which kept stale values, or a result that arrived one cycle early or late, shows up as a mismatch or as a valid flag on the wrong cycle.

// File: rtl/fir_cf_pkg.sv
package fir_cf_pkg;

    parameter int DATA_W    = 8;
    parameter int COEF_W    = 8;
    parameter int ACC_GUARD = 4;
    localparam int ACC_W    = DATA_W + COEF_W + ACC_GUARD;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    // registered state of one processing element
    typedef struct packed {
        sample_t x;    // sample moving towards the last element
        logic    xv;   // sample slot tag (zero samples included)
        coef_t   w;    // coefficient moving towards element 0
        logic    wv;   // coefficient slot tag
        logic    wl;   // marks tap 0, closes an output
        acc_t    acc;  // in-place accumulator
        acc_t    ch;   // unload chain stage
        logic    chv;  // unload chain stage valid
    } cell_st_t;

    function automatic acc_t mac(input acc_t a, input sample_t x, input coef_t w);
        acc_t xe;
        acc_t we;
        xe = acc_t'(x);
        we = acc_t'(w);
        return a + xe * we;
    endfunction

endpackage

// File: rtl/fir_cf_feed.sv
module fir_cf_feed
    import fir_cf_pkg::*;
#(
    parameter int TAPS = 5
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    samp_valid,
    input  sample_t samp_data,
    input  logic    coef_valid,
    input  coef_t   coef_data,
    output logic    samp_slot,
    output sample_t x_inj,
    output logic    xv_inj,
    output coef_t   w_inj,
    output logic    wv_inj,
    output logic    wl_inj
);

    localparam int            KW   = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam logic [KW-1:0] KMAX = KW'(TAPS - 1);
    // coefficients enter on the phase that makes them meet samples inside every element
    localparam logic          WPH  = 1'((TAPS - 1) % 2);

    typedef struct packed {
        logic                  ph;
        logic [KW-1:0]         kidx;
        coef_t [TAPS-1:0]      coef;
    } feed_st_t;

    feed_st_t st_d, st_q;
    logic     wslot;

    always_comb begin
        st_d  = st_q;
        wslot = (st_q.ph == WPH);
        st_d.ph = ~st_q.ph;
        if (coef_valid) begin
            for (int i = 0; i < TAPS - 1; i++) begin
                st_d.coef[i] = st_q.coef[i+1];
            end
            st_d.coef[TAPS-1] = coef_data;
        end
        // taps leave in descending order, tap 0 closes each output
        if (wslot) begin
            st_d.kidx = (st_q.kidx == '0) ? KMAX : st_q.kidx - KW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kidx <= KMAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign samp_slot = ~st_q.ph;
    assign xv_inj    = samp_slot;
    assign x_inj     = (samp_slot && samp_valid) ? samp_data : '0;
    assign wv_inj    = wslot;
    assign w_inj     = wslot ? st_q.coef[st_q.kidx] : '0;
    assign wl_inj    = wslot && (st_q.kidx == '0);

endmodule

// File: rtl/fir_cf_cell.sv
module fir_cf_cell
    import fir_cf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sample_t x_in,
    input  logic    xv_in,
    input  coef_t   w_in,
    input  logic    wv_in,
    input  logic    wl_in,
    input  acc_t    ch_in,
    input  logic    chv_in,
    output sample_t x_out,
    output logic    xv_out,
    output coef_t   w_out,
    output logic    wv_out,
    output logic    wl_out,
    output acc_t    ch_out,
    output logic    chv_out,
    output logic    done
);

    cell_st_t st_d, st_q;
    acc_t     sum_c;

    always_comb begin
        st_d  = st_q;
        sum_c = mac(st_q.acc, st_q.x, st_q.w);
        done  = st_q.xv & st_q.wl;

        st_d.x  = x_in;
        st_d.xv = xv_in;
        st_d.w  = w_in;
        st_d.wv = wv_in;
        st_d.wl = wl_in;

        // a meeting happens only where a sample slot is present
        if (st_q.xv) begin
            st_d.acc = done ? '0 : sum_c;
        end

        st_d.ch  = done ? sum_c : ch_in;
        st_d.chv = done | chv_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_out   = st_q.x;
    assign xv_out  = st_q.xv;
    assign w_out   = st_q.w;
    assign wv_out  = st_q.wv;
    assign wl_out  = st_q.wl;
    assign ch_out  = st_q.ch;
    assign chv_out = st_q.chv;

endmodule

// File: rtl/fir_cf_top.sv
module fir_cf_top
    import fir_cf_pkg::*;
#(
    parameter int TAPS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_valid,
    input  logic [DATA_W-1:0] samp_data,
    output logic              samp_slot,
    input  logic              coef_valid,
    input  logic [COEF_W-1:0] coef_data,
    output logic              res_valid,
    output logic [ACC_W-1:0]  res_data
);

    sample_t x_inj;
    logic    xv_inj;
    coef_t   w_inj;
    logic    wv_inj;
    logic    wl_inj;

    sample_t         x_b  [TAPS];
    coef_t           w_b  [TAPS];
    acc_t            ch_b [TAPS];
    logic [TAPS-1:0] xv_vec;
    logic [TAPS-1:0] wv_vec;
    logic [TAPS-1:0] wl_vec;
    logic [TAPS-1:0] chv_vec;
    logic [TAPS-1:0] done_vec;

    fir_cf_feed #(.TAPS(TAPS)) u_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_valid (samp_valid),
        .samp_data  (samp_data),
        .coef_valid (coef_valid),
        .coef_data  (coef_data),
        .samp_slot  (samp_slot),
        .x_inj      (x_inj),
        .xv_inj     (xv_inj),
        .w_inj      (w_inj),
        .wv_inj     (wv_inj),
        .wl_inj     (wl_inj)
    );

    for (genvar c = 0; c < TAPS; c++) begin : g_cell
        sample_t x_src;
        logic    xv_src;
        coef_t   w_src;
        logic    wv_src;
        logic    wl_src;
        acc_t    ch_src;
        logic    chv_src;

        if (c == 0) begin : g_head
            assign x_src   = x_inj;
            assign xv_src  = xv_inj;
            assign ch_src  = '0;
            assign chv_src = 1'b0;
        end else begin : g_body
            assign x_src   = x_b[c-1];
            assign xv_src  = xv_vec[c-1];
            assign ch_src  = ch_b[c-1];
            assign chv_src = chv_vec[c-1];
        end

        if (c == TAPS - 1) begin : g_tail
            assign w_src  = w_inj;
            assign wv_src = wv_inj;
            assign wl_src = wl_inj;
        end else begin : g_mid
            assign w_src  = w_b[c+1];
            assign wv_src = wv_vec[c+1];
            assign wl_src = wl_vec[c+1];
        end

        fir_cf_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .x_in    (x_src),
            .xv_in   (xv_src),
            .w_in    (w_src),
            .wv_in   (wv_src),
            .wl_in   (wl_src),
            .ch_in   (ch_src),
            .chv_in  (chv_src),
            .x_out   (x_b[c]),
            .xv_out  (xv_vec[c]),
            .w_out   (w_b[c]),
            .wv_out  (wv_vec[c]),
            .wl_out  (wl_vec[c]),
            .ch_out  (ch_b[c]),
            .chv_out (chv_vec[c]),
            .done    (done_vec[c])
        );
    end

    assign res_valid = chv_vec[TAPS-1];
    assign res_data  = ch_b[TAPS-1];

endmodule

// File: rtl/fir_cf_chk.sv
module fir_cf_chk
    import fir_cf_pkg::*;
#(
    parameter int TAPS = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            samp_slot,
    input logic            res_valid,
    input logic [TAPS-1:0] xv_vec,
    input logic [TAPS-1:0] wv_vec,
    input logic [TAPS-1:0] wl_vec,
    input logic [TAPS-1:0] chv_vec,
    input logic [TAPS-1:0] done_vec,
    input sample_t         x_last,
    input coef_t           w_first
);

    localparam int            PW    = $clog2(2 * TAPS + 1);
    localparam logic [PW-1:0] PRIME = PW'(2 * TAPS);

    logic [PW-1:0]   prime_q;
    logic [TAPS-1:0] collide;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prime_q <= '0;
        end else if (prime_q != PRIME) begin
            prime_q <= prime_q + PW'(1);
        end
    end

    always_comb begin
        collide = '0;
        for (int c = 1; c < TAPS; c++) begin
            collide[c] = done_vec[c] & chv_vec[c-1];
        end
    end

    // R1
    slot_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (samp_slot != $past(samp_slot)));

    // R2
    slot_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_slot |=> xv_vec[0]);

    // R2
    bubble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xv_vec[TAPS-1] |-> x_last == '0) and (!wv_vec[0] |-> w_first == '0));

    // R6
    res_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    unload_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide == '0);

    // R6
    meet_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prime_q == PRIME) |-> (xv_vec == wv_vec));

    // R4
    one_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec) && ($countones(wl_vec) <= ((TAPS + 1) / 2)));

endmodule

bind fir_cf_top fir_cf_chk #(.TAPS(TAPS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp_slot(samp_slot),
    .res_valid(res_valid),
    .xv_vec   (xv_vec),
    .wv_vec   (wv_vec),
    .wl_vec   (wl_vec),
    .chv_vec  (chv_vec),
    .done_vec (done_vec),
    .x_last   (x_b[TAPS-1]),
    .w_first  (w_b[0])
);

// File: tb/fir_cf_top_tb_top.sv
module fir_cf_top_tb_top;
    import fir_cf_pkg::*;

    localparam int TAPS       = 5;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              samp_valid = 1'b0;
    logic [DATA_W-1:0] samp_data = '0;
    logic              samp_slot;
    logic              coef_valid = 1'b0;
    logic [COEF_W-1:0] coef_data = '0;
    logic              res_valid;
    logic [ACC_W-1:0]  res_data;

    int     edge_cnt = 0;
    int     checks = 0;
    int     fails = 0;
    bit     armed = 1'b0;
    bit     finished = 1'b0;
    bit     prev_slot = 1'b0;
    string  cur_req = "R4";
    int     exp_edge [$];
    longint exp_val  [$];
    longint hist     [$];
    longint coef_m   [TAPS];

    fir_cf_top #(.TAPS(TAPS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_valid(samp_valid),
        .samp_data (samp_data),
        .samp_slot (samp_slot),
        .coef_valid(coef_valid),
        .coef_data (coef_data),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, edge_cnt);
        end
    endtask

    function automatic longint model_y();
        longint s = 0;
        int n = hist.size() - 1;
        for (int k = 0; k < TAPS; k++) begin
            if (n - k >= 0) s += coef_m[k] * hist[n-k];
        end
        return s;
    endfunction

    task automatic tick(input bit sv, input logic [DATA_W-1:0] sd,
                        input bit cv, input logic [COEF_W-1:0] cd);
        longint act;
        @(negedge clk);
        act = longint'($signed(res_data));
        if (exp_edge.size() > 0 && exp_edge[0] == edge_cnt) begin
            if (armed) begin
                chk(res_valid == 1'b1, "R5 valid", longint'(res_valid), 1);
                chk(act == exp_val[0], cur_req, act, exp_val[0]);
            end
            void'(exp_edge.pop_front());
            void'(exp_val.pop_front());
        end else if (armed) begin
            chk(res_valid == 1'b0, "R6 idle", longint'(res_valid), 0);
        end
        chk(samp_slot != prev_slot, "R1 slot", longint'(samp_slot), longint'(!prev_slot));
        prev_slot  = samp_slot;
        samp_valid = sv;
        samp_data  = sd;
        coef_valid = cv;
        coef_data  = cd;
        if (samp_slot) begin
            hist.push_back(sv ? longint'($signed(sd)) : 0);
            exp_edge.push_back(edge_cnt + 1 + TAPS);
            exp_val.push_back(model_y());
        end
        if (cv) begin
            for (int i = 0; i < TAPS - 1; i++) coef_m[i] = coef_m[i+1];
            coef_m[TAPS-1] = longint'($signed(cd));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, 1'b0, '0);
    endtask

    task automatic load_taps(input int t0, input int t1, input int t2, input int t3, input int t4);
        int v [TAPS];
        v = '{t0, t1, t2, t3, t4};
        for (int i = 0; i < TAPS; i++) tick(1'b0, '0, 1'b1, COEF_W'(v[i]));
        idle(4 * TAPS);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        for (int i = 0; i < TAPS; i++) coef_m[i] = 0;

        // R7: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(res_valid == 1'b0, "R7 res_valid", longint'(res_valid), 0);
        chk(res_data == '0, "R7 res_data", longint'(res_data), 0);
        chk(samp_slot == 1'b1, "R7 samp_slot", longint'(samp_slot), 1);
        rst_n     = 1'b1;
        prev_slot = 1'b1;

        // R3: tap order seen through an impulse
        load_taps(3, -2, 7, 1, -5);
        armed   = 1'b1;
        cur_req = "R3 impulse";
        while (!samp_slot) tick(1'b0, '0, 1'b0, '0);
        tick(1'b1, DATA_W'(1), 1'b0, '0);
        idle(4 * TAPS);

        // R2: random slots, some empty, junk on off-slot cycles
        cur_req = "R2 slot data";
        for (int i = 0; i < 400; i++) begin
            tick($urandom_range(0, 3) != 0, DATA_W'($urandom_range(0, 255)), 1'b0, '0);
        end
        idle(4 * TAPS);

        // R4: largest magnitude products, every slot full
        armed = 1'b0;
        load_taps(-128, -128, -128, -128, -128);
        armed   = 1'b1;
        cur_req = "R4 extreme";
        for (int i = 0; i < 60; i++) tick(1'b1, DATA_W'(-128), 1'b0, '0);
        idle(4 * TAPS);
        armed = 1'b0;
        load_taps(127, 127, 127, 127, 127);
        armed = 1'b1;
        for (int i = 0; i < 60; i++) tick(1'b1, DATA_W'(-128), 1'b0, '0);
        idle(4 * TAPS);

        // R8: reload with random taps, then random data
        for (int r = 0; r < 3; r++) begin
            armed = 1'b0;
            load_taps($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
                      $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
                      $urandom_range(0, 255) - 128);
            armed   = 1'b1;
            cur_req = "R8 reload";
            for (int i = 0; i < 300; i++) begin
                tick($urandom_range(0, 4) != 0, DATA_W'($urandom_range(0, 255)), 1'b0, '0);
            end
            idle(4 * TAPS);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule